// File: doc/BRIEF.md
# Level Interrupt Routing Table with Vector Acknowledge

The block holds a small table of interrupt routing entries, one per level-sensitive interrupt input. Software reaches the table indirectly: it writes an entry word number into a selector register, then reads or writes that word through a 32-bit window register. Each entry stores an 8-bit vector, a mask flag and an in-service flag. The in-service flag is set by hardware and cannot be written by software.

When an input is high, its entry is unmasked and its in-service flag is clear, the entry asks to send a message. Requests go out one at a time on a valid/ready port that carries the entry number and the vector. When several entries are waiting, the lowest entry number goes first. The in-service flag is set on the cycle the handshake completes, so a held input does not send the message again.

Software acknowledges an interrupt by writing its vector to an end-of-service register. Every entry whose vector matches the low byte of that write has its in-service flag cleared on the same edge. An input that is still high then requests again, so an early acknowledge loses no interrupt.

Top module: `irq_route_table`

## Requirements
- R1: After reset every table word, the selector and the window read 0, and `msg_valid_o` is low.
- R2: The bus byte offsets are fixed. The selector is at 00h and holds bits 7:0. The window is at 10h. Entry n's low word is at selector value 10h+2n and its high word at 11h+2n. The high word is 32 bits of plain storage. Any other selector value reads 0 through the window.
- R3: A window write whose byte enables are not all four set (`bus_be_i` != 4'hF) changes nothing.
- R4: In the low word, bits 7:0 are the vector, bit 16 is the mask and bit 14 is the in-service flag. Bit 14 is read-only: writes to it have no effect. All other bits are read/write storage.
- R5: An entry whose input is high, whose mask is 0 and whose in-service flag is 0 drives `msg_valid_o`. It also drives its entry number on `msg_entry_o` and its vector on `msg_vector_o`.
- R6: The in-service flag is set on the edge where `msg_valid_o` and `msg_ready_i` are both high. After that the entry sends no further message while the flag stays set.
- R7: When several entries are pending, the lowest entry number is offered first.
- R8: A write to offset 40h compares only bits 7:0 with every entry's vector and ignores bits 31:8. It clears the in-service flag of all matching entries on the same edge.
- R9: An entry whose input is still high when its flag is cleared sends its message again.
- R10: Reads of offset 40h and of any offset other than 00h and 10h return 0.
- R11: If a handshake and a matching acknowledge fall on the same edge for one entry, the in-service flag ends up set.
- R12: An entry with mask 1 sends no message, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset in the block's window |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational during a read |
| irq_i | input | N_ENT | Level interrupt inputs, one per entry |
| msg_valid_o | output | 1 | A message is offered |
| msg_ready_i | input | 1 | Receiver accepts the message |
| msg_entry_o | output | ENT_W | Entry number of the offered message |
| msg_vector_o | output | 8 | Vector of the offered message |

## Verification
Two things can happen to the same in-service flag on one clock edge: the handshake that sets it, and an acknowledge write that clears it. The bench provokes this by holding an entry pending with ready low. It then raises ready and writes that entry's vector to the acknowledge register in the same cycle. The expected result is a set flag with a single message consumed, which the bench confirms by reading the entry back and by checking that the scoreboard sees no repeat message. Shared vectors are also exercised: one acknowledge must clear two entries at once and leave a third entry alone.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned BE_W    = REG_W / 8;

  localparam logic [ADDR_W-1:0] OFS_SEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_WIN = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ACK = 8'h40;

  localparam logic [IDX_W-1:0]  TBL_BASE = 8'h10;

  localparam int unsigned BIT_INSVC = 14;
  localparam int unsigned BIT_MASK  = 16;

  localparam logic [REG_W-1:0] INSVC_MSK = REG_W'(1) << BIT_INSVC;
endpackage

// File: rtl/irt_regif.sv
module irt_regif
  import irt_pkg::*;
#(
  parameter int unsigned N_ENT = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BE_W-1:0]             be_i,
  input  logic [REG_W-1:0]            wdata_i,
  input  logic [N_ENT-1:0][REG_W-1:0] lo_words_i,
  input  logic [N_ENT-1:0][REG_W-1:0] hi_words_i,
  output logic [REG_W-1:0]            rdata_o,
  output logic [N_ENT-1:0]            wr_lo_o,
  output logic [N_ENT-1:0]            wr_hi_o,
  output logic                        ack_stb_o,
  output logic [VEC_W-1:0]            ack_vec_o
);
  localparam int unsigned TBL_WORDS = 2 * N_ENT;

  logic [IDX_W-1:0] sel_q;
  logic [IDX_W-1:0] rel_idx;
  logic             in_tbl;
  logic             wr_acc, rd_acc, win_wr;

  assign wr_acc  = req_i & we_i;
  assign rd_acc  = req_i & ~we_i;
  assign win_wr  = wr_acc & (addr_i == OFS_WIN) & (be_i == {BE_W{1'b1}});
  assign rel_idx = sel_q - TBL_BASE;
  assign in_tbl  = (sel_q >= TBL_BASE) && (32'(rel_idx) < TBL_WORDS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   sel_q <= '0;
    else if (wr_acc && addr_i == OFS_SEL && be_i[0]) sel_q <= wdata_i[IDX_W-1:0];
  end

  for (genvar n = 0; n < N_ENT; n++) begin : g_dec
    assign wr_lo_o[n] = win_wr & in_tbl & (32'(rel_idx) == 2*n);
    assign wr_hi_o[n] = win_wr & in_tbl & (32'(rel_idx) == 2*n + 1);
  end

  assign ack_stb_o = wr_acc & (addr_i == OFS_ACK);
  assign ack_vec_o = wdata_i[VEC_W-1:0];

  logic [REG_W-1:0] win_rd;
  always_comb begin
    win_rd = '0;
    for (int n = 0; n < N_ENT; n++) begin
      if (in_tbl && 32'(rel_idx) == 2*n)     win_rd = lo_words_i[n];
      if (in_tbl && 32'(rel_idx) == 2*n + 1) win_rd = hi_words_i[n];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      unique case (addr_i)
        OFS_SEL: rdata_o = {{(REG_W-IDX_W){1'b0}}, sel_q};
        OFS_WIN: rdata_o = win_rd;
        default: rdata_o = '0;
      endcase
    end
  end

  p_partial_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && addr_i == OFS_WIN && be_i != {BE_W{1'b1}}) |-> (wr_lo_o == '0 && wr_hi_o == '0));

  p_single_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo_o, wr_hi_o}));
endmodule

// File: rtl/irt_entry.sv
module irt_entry
  import irt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ack_stb_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  input  logic             irq_i,
  input  logic             fire_i,
  output logic [REG_W-1:0] lo_word_o,
  output logic [REG_W-1:0] hi_word_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             req_o
);
  logic [REG_W-1:0] lo_q, hi_q;
  logic             insvc_q;
  logic             ack_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo_i) lo_q <= wdata_i & ~INSVC_MSK;
      if (wr_hi_i) hi_q <= wdata_i;
    end
  end

  assign ack_hit = ack_stb_i && (ack_vec_i == lo_q[VEC_W-1:0]);

  // handshake wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      insvc_q <= 1'b0;
    else if (fire_i)  insvc_q <= 1'b1;
    else if (ack_hit) insvc_q <= 1'b0;
  end

  assign lo_word_o = lo_q | (insvc_q ? INSVC_MSK : '0);
  assign hi_word_o = hi_q;
  assign vector_o  = lo_q[VEC_W-1:0];
  assign req_o     = irq_i & ~lo_q[BIT_MASK] & ~insvc_q;

  p_fire_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> insvc_q);

  p_set_only_on_fire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(insvc_q) |-> $past(fire_i));

  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit && !fire_i) |=> !insvc_q);

  p_fire_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> (irq_i && !lo_q[BIT_MASK] && !insvc_q));

  p_store_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/irt_arb.sv
module irt_arb #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned ENT_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] pend_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [ENT_W-1:0] idx_o,
  output logic [N_ENT-1:0] fire_o
);
  logic found;

  always_comb begin
    found = 1'b0;
    idx_o = '0;
    for (int n = 0; n < N_ENT; n++) begin
      if (pend_i[n] && !found) begin
        found = 1'b1;
        idx_o = ENT_W'(n);
      end
    end
  end

  assign valid_o = found;

  for (genvar n = 0; n < N_ENT; n++) begin : g_fire
    assign fire_o[n] = valid_o & ready_i & (idx_o == ENT_W'(n));
  end

  p_lowest_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && $countones(pend_i & ~({N_ENT{1'b1}} << idx_o)) == 0));

  p_one_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire_o));
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irt_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned ENT_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [N_ENT-1:0]  irq_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [ENT_W-1:0]  msg_entry_o,
  output logic [7:0]        msg_vector_o
);
  logic [N_ENT-1:0][REG_W-1:0] lo_words, hi_words;
  logic [N_ENT-1:0][VEC_W-1:0] vectors;
  logic [N_ENT-1:0]            wr_lo, wr_hi, pend, fire;
  logic                        ack_stb;
  logic [VEC_W-1:0]            ack_vec;

  irt_regif #(.N_ENT(N_ENT)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_req_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .be_i       (bus_be_i),
    .wdata_i    (bus_wdata_i),
    .lo_words_i (lo_words),
    .hi_words_i (hi_words),
    .rdata_o    (bus_rdata_o),
    .wr_lo_o    (wr_lo),
    .wr_hi_o    (wr_hi),
    .ack_stb_o  (ack_stb),
    .ack_vec_o  (ack_vec)
  );

  for (genvar n = 0; n < N_ENT; n++) begin : g_ent
    irt_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (wr_lo[n]),
      .wr_hi_i   (wr_hi[n]),
      .wdata_i   (bus_wdata_i),
      .ack_stb_i (ack_stb),
      .ack_vec_i (ack_vec),
      .irq_i     (irq_i[n]),
      .fire_i    (fire[n]),
      .lo_word_o (lo_words[n]),
      .hi_word_o (hi_words[n]),
      .vector_o  (vectors[n]),
      .req_o     (pend[n])
    );
  end

  irt_arb #(.N_ENT(N_ENT), .ENT_W(ENT_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .idx_o   (msg_entry_o),
    .fire_o  (fire)
  );

  assign msg_vector_o = vectors[msg_entry_o];

  p_masked_silent_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !lo_words[msg_entry_o][BIT_MASK]);

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !msg_valid_o || irq_i != '0);
endmodule

// File: tb/sim_irq_route_table.sv
`timescale 1ns/1ps
module sim_irq_route_table;
  localparam int N = 8;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0, rdata;
  logic [N-1:0] irq = 0;
  logic        mvalid, mready = 1;
  logic [2:0]  ment;
  logic [7:0]  mvec;

  int total = 0, failed = 0;
  bit done = 0;
  logic [10:0] expq[$];

  always #2.5 clk = ~clk;

  irq_route_table u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_i(irq),
    .msg_valid_o(mvalid), .msg_ready_i(mready), .msg_entry_o(ment), .msg_vector_o(mvec)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; be = 4'hF;
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic rd_word(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    rd(8'h10, d);
  endtask

  task automatic expect_msg(input logic [2:0] e, input logic [7:0] v);
    expq.push_back({e, v});
  endtask

  // monitor: a handshake happens at the next rising edge
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && mvalid && mready) begin
      if (expq.size() == 0) check(0, "R6 unexpected message", {21'h0, ment, mvec}, 32'h0);
      else begin
        logic [10:0] e;
        e = expq.pop_front();
        check({ment, mvec} == e, "R5/R7 message order", {21'h0, ment, mvec}, {21'h0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(8'h00, d); check(d == 0, "R1 selector reset", d, 0);
    rd_word(8'h10, d); check(d == 0, "R1 entry reset", d, 0);
    check(!mvalid, "R1 valid low", mvalid, 0);

    // R2 programming and layout
    wr(8'h00, 32'h0000_0013);
    rd(8'h00, d); check(d == 32'h13, "R2 selector readback", d, 32'h13);
    wr(8'h00, 8'h10); wr(8'h10, 32'h31);
    wr(8'h00, 8'h12); wr(8'h10, 32'h32);
    wr(8'h00, 8'h14); wr(8'h10, 32'h31);
    wr(8'h00, 8'h11); wr(8'h10, 32'hDEAD_BEEF);
    rd_word(8'h11, d); check(d == 32'hDEADBEEF, "R2 high word", d, 32'hDEADBEEF);
    rd_word(8'h30, d); check(d == 0, "R2 unused index", d, 0);

    // R3 partial write ignored
    wr(8'h00, 8'h10); wr(8'h10, 32'h99, 4'h3);
    rd_word(8'h10, d); check(d == 32'h31, "R3 partial write", d, 32'h31);

    // R4 in-service bit read-only
    wr(8'h00, 8'h16); wr(8'h10, 32'h000A_4050);
    rd_word(8'h16, d); check(d == 32'h000A0050, "R4 low word fields", d, 32'h000A0050);

    // R12 masked entry
    wr(8'h00, 8'h16); wr(8'h10, 32'h000B_0050);
    @(negedge clk); irq[3] = 1;
    repeat (4) @(negedge clk);
    check(!mvalid, "R12 masked silent", mvalid, 0);
    irq[3] = 0;

    // R5 R7 priority
    mready = 0;
    @(negedge clk); irq[0] = 1; irq[1] = 1;
    expect_msg(3'd0, 8'h31); expect_msg(3'd1, 8'h32);
    repeat (2) @(negedge clk);
    #1 check(mvalid && ment == 0 && mvec == 8'h31, "R7 lowest offered", {ment, mvec}, {3'd0, 8'h31});
    mready = 1;
    repeat (4) @(negedge clk);
    check(!mvalid, "R6 no repeat while set", mvalid, 0);
    rd_word(8'h10, d); check(d == 32'h4031, "R6 flag set", d, 32'h4031);
    @(negedge clk); irq[2] = 1; expect_msg(3'd2, 8'h31);
    repeat (4) @(negedge clk);

    // R8 shared-vector clear, upper bits ignored
    irq[0] = 0; irq[2] = 0;
    wr(8'h40, 32'hABCD_EF31);
    repeat (2) @(negedge clk);
    rd_word(8'h10, d); check(d == 32'h31, "R8 entry0 cleared", d, 32'h31);
    rd_word(8'h14, d); check(d == 32'h31, "R8 entry2 cleared", d, 32'h31);
    rd_word(8'h12, d); check(d == 32'h4032, "R8 entry1 untouched", d, 32'h4032);

    // R9 reissue
    expect_msg(3'd1, 8'h32);
    wr(8'h40, 32'h32);
    repeat (4) @(negedge clk);
    rd_word(8'h12, d); check(d == 32'h4032, "R9 reissued and set", d, 32'h4032);
    check(expq.size() == 0, "R9 message seen", expq.size(), 0);

    // R10
    rd(8'h40, d); check(d == 0, "R10 ack reads zero", d, 0);
    rd(8'h20, d); check(d == 0, "R10 unused offset", d, 0);

    // R11 handshake and acknowledge collide
    irq[1] = 0;
    wr(8'h40, 32'h32);
    mready = 0;
    @(negedge clk); irq[0] = 1;
    repeat (2) @(negedge clk);
    expect_msg(3'd0, 8'h31);
    mready = 1; req = 1; we = 1; addr = 8'h40; wdata = 32'h31; be = 4'hF;
    @(negedge clk); req = 0; we = 0;
    repeat (3) @(negedge clk);
    rd_word(8'h10, d); check(d == 32'h4031, "R11 set wins", d, 32'h4031);
    check(expq.size() == 0, "R11 single message", expq.size(), 0);
    irq = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule